// File: doc/BRIEF.md
# Prescaled UART Baud Generator

This block supplies the timing for a serial transmitter and receiver. Three counters divide the input clock in turn. A prescale counter comes first, then a baud divisor counter, and the result is the oversampling tick. A fixed thirteen-way counter then turns every thirteenth oversampling tick into a bit tick. Both the prescale and the divisor are programmed with a minus-one encoding through one 32-bit rate word.

A write to the rate word does not act at once. The value waits in a holding register, and a busy status is raised. The new rate is copied into the counters at the next bit boundary, so the bit in progress keeps its length. Software waits for busy to read low before it writes again.

The block also times a line break. The break length is given in bit periods by a separate length register. Setting the break request holds the break-active output high until that many bit ticks have passed. The block then drops break-active and gives a one-cycle done pulse.

Top module: `baud_gen`

## Requirements
- R1: After synchronous reset, rate_busy, brk_active and brk_done are low, and the ticks stay low while reset is asserted. The reset rate is prescale 1 and divisor 1, which gives a bit tick every 13 cycles.
- R2: In the rate word, bits [19:16] hold the prescale minus one (P) and bits [9:0] hold the divisor minus one (D). All other bits are ignored.
- R3: With P and D in effect, a bit tick occurs every (P+1)·13·(D+1) clock cycles. The first oversampling tick after a bit tick comes (P+1)·(D+1) cycles after it.
- R4: Each tick lasts one cycle. Thirteen oversampling ticks occur per bit, and every bit tick coincides with an oversampling tick.
- R5: rate_busy is high from the cycle after a rate write until the next bit tick, and goes low on the following cycle.
- R6: A new rate takes effect at the first bit boundary after the write. If several writes arrive before that boundary, the last one wins.
- R7: After brk_set, brk_active goes high on the next cycle. It stays high for N bit ticks, where N is the stored break length and a length of 0 counts as 1. It falls at the edge of the N-th bit tick, and brk_done pulses high for exactly that one cycle.
- R8: During a break, a brk_set and a break-length write do not change the break in progress. The written length is used by the next break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_wr | input | 1 | Write strobe for the rate word |
| rate_wdata | input | 32 | Rate word: P in [19:16], D in [9:0] |
| rate_busy | output | 1 | A rate change is waiting for a bit boundary |
| brk_len_wr | input | 1 | Write strobe for the break length |
| brk_len_wdata | input | BRK_W | Break length in bit periods |
| brk_set | input | 1 | Request to start a break |
| sample_tick | output | 1 | Oversampling tick, one cycle wide |
| bit_tick | output | 1 | Bit boundary tick, one cycle wide |
| brk_active | output | 1 | Break in progress; the transmit line is held low |
| brk_done | output | 1 | One-cycle pulse when a break ends |

## Verification
The hardest cases to reach are the ones that race a bit boundary. These are a second rate write while a first is still waiting, and a new break request or length write while a break is running. The stimulus writes two different rates on consecutive cycles and measures the bit period that follows the boundary. It also re-requests a break and rewrites the length after the first bit tick of a running break. It then counts the bit ticks seen while break-active is high, and starts one more break to show that the stored length was updated.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    localparam int PRE_W   = 4;
    localparam int DIV_W   = 10;
    localparam int PRE_LSB = 16;
    localparam int DIV_LSB = 0;
    localparam int WORD_W  = 32;
    localparam int OVS     = 13;
    localparam int OVS_W   = $clog2(OVS);

    typedef struct packed {
        logic [PRE_W-1:0] pre_m1;
        logic [DIV_W-1:0] div_m1;
    } rate_cfg_t;

    function automatic rate_cfg_t decode_rate(input logic [WORD_W-1:0] w);
        rate_cfg_t c;
        c.pre_m1 = w[PRE_LSB +: PRE_W];
        c.div_m1 = w[DIV_LSB +: DIV_W];
        return c;
    endfunction
endpackage

// File: rtl/baud_rate_shadow.sv
module baud_rate_shadow
    import baud_gen_pkg::*;
#(
    parameter rate_cfg_t RESET_CFG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              boundary,
    output rate_cfg_t         cfg_active,
    output logic              busy
);
    rate_cfg_t held;
    logic      pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= RESET_CFG;
            cfg_active <= RESET_CFG;
            pending    <= 1'b0;
        end else if (wr) begin
            held    <= decode_rate(wdata);
            pending <= 1'b1;
        end else if (boundary && pending) begin
            cfg_active <= held;
            pending    <= 1'b0;
        end
    end

    assign busy = pending;
endmodule

// File: rtl/baud_div_chain.sv
module baud_div_chain
    import baud_gen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rate_cfg_t cfg,
    output logic      sample_tick,
    output logic      bit_tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [OVS_W-1:0] ovs_cnt;
    logic pre_end, div_end, ovs_end;

    assign pre_end     = (pre_cnt == cfg.pre_m1);
    assign div_end     = (div_cnt == cfg.div_m1);
    assign ovs_end     = (ovs_cnt == OVS_W'(OVS - 1));
    assign sample_tick = !rst && pre_end && div_end;
    assign bit_tick    = sample_tick && ovs_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            ovs_cnt <= '0;
        end else begin
            pre_cnt <= pre_end ? '0 : pre_cnt + 1'b1;
            if (pre_end)
                div_cnt <= div_end ? '0 : div_cnt + 1'b1;
            if (sample_tick)
                ovs_cnt <= ovs_end ? '0 : ovs_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_break_timer.sv
module baud_break_timer #(
    parameter int BRK_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_wr,
    input  logic [BRK_W-1:0] len_wdata,
    input  logic             start,
    input  logic             bit_tick,
    output logic             active,
    output logic             done
);
    logic [BRK_W-1:0] len_q;
    logic [BRK_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            left   <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (len_wr)
                len_q <= len_wdata;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    left   <= len_q;
                end
            end else if (bit_tick) begin
                if (left <= BRK_W'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_gen_pkg::*;
#(
    parameter int BRK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_wr,
    input  logic [WORD_W-1:0] rate_wdata,
    output logic              rate_busy,
    input  logic              brk_len_wr,
    input  logic [BRK_W-1:0]  brk_len_wdata,
    input  logic              brk_set,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              brk_active,
    output logic              brk_done
);
    rate_cfg_t cfg_now;

    baud_rate_shadow #(.RESET_CFG('0)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .wr         (rate_wr),
        .wdata      (rate_wdata),
        .boundary   (bit_tick),
        .cfg_active (cfg_now),
        .busy       (rate_busy)
    );

    baud_div_chain u_chain (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg_now),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    baud_break_timer #(.BRK_W(BRK_W)) u_break (
        .clk       (clk),
        .rst       (rst),
        .len_wr    (brk_len_wr),
        .len_wdata (brk_len_wdata),
        .start     (brk_set),
        .bit_tick  (bit_tick),
        .active    (brk_active),
        .done      (brk_done)
    );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
    input logic clk,
    input logic rst,
    input logic rate_wr,
    input logic rate_busy,
    input logic sample_tick,
    input logic bit_tick,
    input logic brk_active,
    input logic brk_done
);
    // R4: a bit tick only happens together with an oversampling tick
    a_r4_bit_on_sample: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    // R5: a rate write raises busy on the next cycle
    a_r5_write_sets_busy: assert property (@(posedge clk) disable iff (rst)
        rate_wr |=> rate_busy);

    // R5: busy holds until a bit tick arrives
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (rate_busy && !bit_tick) |=> rate_busy);

    // R5: busy clears after the boundary when no new write comes in
    a_r5_busy_clears: assert property (@(posedge clk) disable iff (rst)
        (rate_busy && bit_tick && !rate_wr) |=> !rate_busy);

    // R7: the done pulse comes with the end of break-active
    a_r7_done_with_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_active) |-> brk_done);

    // R7: the done pulse never comes while a break is active
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        brk_done |-> !brk_active);

    // R7: a break only ends on a bit tick
    a_r7_end_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_active) |-> $past(bit_tick));

    // R7: the done pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        brk_done |=> !brk_done);
endmodule

bind baud_gen baud_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rate_wr     (rate_wr),
    .rate_busy   (rate_busy),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .brk_active  (brk_active),
    .brk_done    (brk_done)
);

// File: tb/baud_gen_test.sv
`timescale 1ns/1ps
module baud_gen_test;
    localparam int BRK_W = 16;
    localparam logic [31:0] JUNK = 32'hFFF0_FC00;
    localparam int NV = 6;
    localparam int VP [NV] = '{0, 1, 0, 2, 15, 3};
    localparam int VD [NV] = '{0, 0, 2, 1, 3, 9};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_wr = 1'b0;
    logic [31:0] rate_wdata = '0;
    logic rate_busy;
    logic brk_len_wr = 1'b0;
    logic [BRK_W-1:0] brk_len_wdata = '0;
    logic brk_set = 1'b0;
    logic sample_tick, bit_tick, brk_active, brk_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    baud_gen #(.BRK_W(BRK_W)) uut (
        .clk(clk), .rst(rst), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
        .rate_busy(rate_busy), .brk_len_wr(brk_len_wr),
        .brk_len_wdata(brk_len_wdata), .brk_set(brk_set),
        .sample_tick(sample_tick), .bit_tick(bit_tick),
        .brk_active(brk_active), .brk_done(brk_done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_bit();
        do @(negedge clk); while (!bit_tick);
    endtask

    task automatic wait_idle();
        while (rate_busy) @(negedge clk);
    endtask

    task automatic measure(output int per, output int first_s, output int nsamp,
                           output logic busy1);
        per = 0; first_s = 0; nsamp = 0; busy1 = 1'b0;
        do begin
            @(negedge clk);
            per++;
            if (per == 1) busy1 = rate_busy;
            if (sample_tick) begin
                nsamp++;
                if (first_s == 0) first_s = per;
            end
        end while (!bit_tick);
    endtask

    task automatic write_rate(input int p, input int d);
        rate_wdata = JUNK | (32'(p) << 16) | 32'(d);
        rate_wr = 1'b1;
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    task automatic run_break(input int len, input int exp_ticks, input string tag,
                             input logic disturb);
        int ticks;
        int guard;
        brk_len_wdata = BRK_W'(len);
        brk_len_wr = 1'b1;
        @(negedge clk);
        brk_len_wr = 1'b0;
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
        chk(brk_active == 1'b1, {tag, " break active after set"}, int'(brk_active), 1);
        ticks = 0;
        guard = 0;
        while (brk_active && guard < 5000) begin
            if (bit_tick) begin
                ticks++;
                if (disturb && ticks == 1) begin
                    brk_set = 1'b1;
                    brk_len_wdata = BRK_W'(9);
                    brk_len_wr = 1'b1;
                end
            end
            @(negedge clk);
            brk_set = 1'b0;
            brk_len_wr = 1'b0;
            guard++;
        end
        chk(ticks == exp_ticks, {tag, " bit ticks during break"}, ticks, exp_ticks);
        chk(brk_done == 1'b1, {tag, " done pulse at end"}, int'(brk_done), 1);
        @(negedge clk);
        chk(brk_done == 1'b0, {tag, " done pulse one cycle"}, int'(brk_done), 0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        int per, fs, ns;
        logic b1;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sample_tick == 1'b0 && bit_tick == 1'b0, "R1 ticks low in reset",
            int'(sample_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rate_busy == 1'b0, "R1 busy low after reset", int'(rate_busy), 0);
        chk(brk_active == 1'b0 && brk_done == 1'b0, "R1 break idle after reset",
            int'(brk_active), 0);
        wait_bit();
        measure(per, fs, ns, b1);
        chk(per == 13, "R1 reset bit period", per, 13);

        // R2 R3 R4 R5 R6: table of rates, junk in the unused bits
        for (int i = 0; i < NV; i++) begin
            int exp_bit, exp_s;
            exp_s = (VP[i] + 1) * (VD[i] + 1);
            exp_bit = exp_s * 13;
            wait_idle();
            write_rate(VP[i], VD[i]);
            chk(rate_busy == 1'b1, "R5 busy after write", int'(rate_busy), 1);
            wait_bit();
            chk(rate_busy == 1'b1, "R5 busy until boundary", int'(rate_busy), 1);
            measure(per, fs, ns, b1);
            chk(b1 == 1'b0, "R5 busy clears after boundary", int'(b1), 0);
            chk(per == exp_bit, "R2 R3 R6 bit period", per, exp_bit);
            chk(fs == exp_s, "R3 first sample spacing", fs, exp_s);
            chk(ns == 13, "R4 samples per bit", ns, 13);
        end

        // R6: two writes before a boundary, last one wins
        wait_idle();
        write_rate(2, 0);
        write_rate(0, 4);
        wait_bit();
        measure(per, fs, ns, b1);
        chk(per == 65, "R6 last write wins", per, 65);

        // fast rate for the break tests
        wait_idle();
        write_rate(0, 0);
        wait_bit();
        measure(per, fs, ns, b1);
        chk(per == 13, "R6 fast rate restored", per, 13);

        // R7: break length 3 and length 0
        run_break(3, 3, "R7 len3", 1'b0);
        run_break(0, 1, "R7 len0", 1'b0);
        // R8: re-request and length write during a break are ignored
        run_break(4, 4, "R8 disturbed", 1'b1);
        // R8: the length written during that break is used next time
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
        begin
            int t;
            int g;
            t = 0;
            g = 0;
            while (brk_active && g < 5000) begin
                if (bit_tick) t++;
                @(negedge clk);
                g++;
            end
            chk(t == 9, "R8 stored length used by next break", t, 9);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule